// File: doc/BRIEF.md
# EEPROM Region Protection Controller

This block screens every read, erase and program request aimed at a 256-byte nonvolatile array. The array occupies addresses 0x100 to 0x1FF. A lower window of 32 bytes can always be written. The upper 224 bytes can be locked by a protection option bit. The block also holds a security option bit, which gates entry to test mode. Both option bits have a stored value and an effective value. Register writes change the stored value. The effective value is loaded from the stored value only at a reset.

Each request gets a registered accept or reject one cycle later. An accepted erase or program marks the array busy and turns the high-voltage pump on. The pump stays on until the operation reports completion or STOP mode is entered. WAIT mode leaves it running. A separate input selects whether the pump is clocked from the CPU clock or from the RC oscillator.

Two resets are used. `rst_ni` is the asynchronous power-on reset: it erases both stored bits to 1 and loads them as effective. `ext_rst_i` is a synchronous external reset: it reloads the effective bits from the stored bits and clears the request and pump state.

Top module: `eeprom_guard`

## Requirements
- R1: Erase (op 1) and program (op 2) with `latch_i` high are accepted at addresses 0x100..0x11F whatever the protection state. Read (op 0) is accepted anywhere in 0x100..0x1FF.
- R2: While effective protection is 1, erase and program at 0x120..0x1FF are rejected. Reads there are still accepted.
- R3: Effective protection and effective security change only on a reset. Option writes made between resets do not alter request screening.
- R4: A write with `opt_wdata_i[0]`=0 clears the stored protection bit only when `latch_i` is high in the same cycle. A write with `opt_wdata_i[0]`=1 always sets it.
- R5: The following requests are rejected: erase or program with `latch_i` low, op code 3, and any address outside 0x100..0x1FF.
- R6: A request sampled at a clock edge gives `resp_valid_o`=1 and the verdict on `resp_ok_o` after that edge. `rej_flag_o` is set by a reject and cleared by an accept.
- R7: `test_ok_o` is `test_req_i` gated by effective security, registered. A write with `opt_wdata_i[1]`=0 clears stored security. A write with `opt_wdata_i[1]`=1 is ignored.
- R8: `selfchk_i` returns stored security to 1 and pulses `erase_all_o` for one cycle.
- R9: `stop_i` clears the busy state, so `pump_en_o` is low after the next edge. Erase or program requested while `stop_i` is high is rejected.
- R10: `wait_i` has no effect. The pump stays enabled through WAIT.
- R11: `pump_en_o` rises only after an accepted erase or program and falls on `op_done_i`. An erase or program requested while busy is rejected.
- R12: `pump_clk_sel_o` follows `rc_sel_i` one cycle later (1 = RC oscillator, 0 = CPU clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_i | input | 1 | Synchronous external reset; reloads effective option bits |
| opt_we_i | input | 1 | Option register write strobe |
| opt_wdata_i | input | 2 | Option write data: bit0 protection, bit1 security |
| latch_i | input | 1 | Latch-enable control bit |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 9 | Request address |
| req_op_i | input | 2 | Operation: 0 read, 1 erase, 2 program, 3 reserved |
| op_done_i | input | 1 | Current erase or program finished |
| stop_i | input | 1 | STOP mode |
| wait_i | input | 1 | WAIT mode |
| rc_sel_i | input | 1 | Pump clock from RC oscillator |
| test_req_i | input | 1 | Test mode entry request |
| selfchk_i | input | 1 | Self-check entry |
| resp_valid_o | output | 1 | Verdict valid |
| resp_ok_o | output | 1 | Request accepted |
| rej_flag_o | output | 1 | Most recent verdict was a reject |
| pump_en_o | output | 1 | High-voltage pump enable |
| pump_clk_sel_o | output | 1 | Pump clock select |
| test_ok_o | output | 1 | Test mode entry granted |
| erase_all_o | output | 1 | Full array erase pulse |

## Verification
STOP entry and a new erase request can arrive in the same cycle. So can a register write and the reset that would make it effective. The bench holds `stop_i` high while it issues an erase to the open window. It expects a reject, with the pump still off. It also writes the protection bit and then pulses the external reset. The bench then judges screening against the value the reset captured, not the value most recently written.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef struct packed {
    logic sec;
    logic prot;
  } opt_t;
endpackage

// File: rtl/eeprom_opt_regs.sv
module eeprom_opt_regs
  import eeprom_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic opt_we_i,
  input  opt_t opt_wdata_i,
  input  logic latch_i,
  input  logic selfchk_i,
  output logic prot_eff_o,
  output logic sec_eff_o,
  output logic erase_all_o
);
  logic prot_nv_q, sec_nv_q, prot_eff_q, sec_eff_q, erase_all_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_nv_q <= 1'b1;
      sec_nv_q  <= 1'b1;
    end else begin
      if (opt_we_i) begin
        if (opt_wdata_i.prot) prot_nv_q <= 1'b1;
        else if (latch_i)     prot_nv_q <= 1'b0;
        if (!opt_wdata_i.sec) sec_nv_q  <= 1'b0;
      end
      if (selfchk_i) sec_nv_q <= 1'b1;
    end
  end

  // effective copies load only at reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_eff_q <= 1'b1;
      sec_eff_q  <= 1'b1;
    end else if (ext_rst_i) begin
      prot_eff_q <= prot_nv_q;
      sec_eff_q  <= sec_nv_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) erase_all_q <= 1'b0;
    else         erase_all_q <= selfchk_i;
  end

  assign prot_eff_o  = prot_eff_q;
  assign sec_eff_o   = sec_eff_q;
  assign erase_all_o = erase_all_q;

  AST_EFF_ONLY_AT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_eff_q) |-> $past(ext_rst_i)); // R3
  AST_PROT_CLR_NEEDS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_nv_q) |-> $past(latch_i)); // R4
  AST_SEC_SET_BY_SELFCHK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_nv_q) |-> $past(selfchk_i)); // R8
endmodule

// File: rtl/eeprom_req_screen.sv
module eeprom_req_screen
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int BASE    = 256,
  parameter int SIZE    = 256,
  parameter int OPEN_SZ = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_op_i,
  input  logic              latch_i,
  input  logic              prot_eff_i,
  input  logic              stop_i,
  input  logic              busy_i,
  output logic              acc_wr_o,
  output logic              resp_valid_o,
  output logic              resp_ok_o,
  output logic              rej_flag_o
);
  localparam logic [ADDR_W:0] LO_A   = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI_A   = (ADDR_W+1)'(BASE + SIZE);
  localparam logic [ADDR_W:0] LOCK_A = (ADDR_W+1)'(BASE + OPEN_SZ);

  logic [ADDR_W:0] addr_x;
  logic in_range, in_lock, is_wr, ok_c, take;
  logic vld_q, ok_q, rej_q;
  op_e  op;

  assign addr_x   = {1'b0, req_addr_i};
  assign op       = op_e'(req_op_i);
  assign in_range = (addr_x >= LO_A) && (addr_x < HI_A);
  assign in_lock  = addr_x >= LOCK_A;
  assign is_wr    = (op == OP_ERASE) || (op == OP_PROG);
  assign take     = req_valid_i && !ext_rst_i;

  always_comb begin
    ok_c = 1'b0;
    unique case (op)
      OP_READ:           ok_c = in_range;
      OP_ERASE, OP_PROG: ok_c = in_range && latch_i && !stop_i && !busy_i &&
                                !(prot_eff_i && in_lock);
      default:           ok_c = 1'b0;
    endcase
  end

  assign acc_wr_o = take && ok_c && is_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      rej_q <= 1'b0;
    end else if (ext_rst_i) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      vld_q <= req_valid_i;
      ok_q  <= req_valid_i && ok_c;
      if (req_valid_i) rej_q <= !ok_c;
    end
  end

  assign resp_valid_o = vld_q;
  assign resp_ok_o    = ok_q;
  assign rej_flag_o   = rej_q;

  AST_UPPER_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && prot_eff_i && is_wr && in_lock |=> resp_valid_o && !resp_ok_o); // R2
  AST_STOP_REJECTS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && stop_i && is_wr |=> !resp_ok_o); // R9
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> resp_valid_o); // R6
endmodule

// File: rtl/eeprom_pump_ctrl.sv
module eeprom_pump_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic acc_wr_i,
  input  logic op_done_i,
  input  logic stop_i,
  input  logic wait_i,
  input  logic rc_sel_i,
  output logic busy_o,
  output logic pump_en_o,
  output logic pump_clk_sel_o
);
  logic busy_q, sel_q;

  // STOP forces read mode; WAIT deliberately not decoded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           busy_q <= 1'b0;
    else if (ext_rst_i || stop_i || op_done_i) busy_q <= 1'b0;
    else if (acc_wr_i)                     busy_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= rc_sel_i;
  end

  assign busy_o         = busy_q;
  assign pump_en_o      = busy_q;
  assign pump_clk_sel_o = sel_q;

  AST_STOP_DROPS_PUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pump_en_o); // R9
  AST_PUMP_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> $past(acc_wr_i)); // R11
  AST_WAIT_KEEPS_PUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_en_o && wait_i && !stop_i && !op_done_i && !ext_rst_i |=> pump_en_o); // R10
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int BASE    = 256,
  parameter int SIZE    = 256,
  parameter int OPEN_SZ = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_i,
  input  logic              opt_we_i,
  input  logic [1:0]        opt_wdata_i,
  input  logic              latch_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_op_i,
  input  logic              op_done_i,
  input  logic              stop_i,
  input  logic              wait_i,
  input  logic              rc_sel_i,
  input  logic              test_req_i,
  input  logic              selfchk_i,
  output logic              resp_valid_o,
  output logic              resp_ok_o,
  output logic              rej_flag_o,
  output logic              pump_en_o,
  output logic              pump_clk_sel_o,
  output logic              test_ok_o,
  output logic              erase_all_o
);
  logic prot_eff, sec_eff, busy, acc_wr, test_ok_q;

  eeprom_opt_regs u_opt (
    .clk_i, .rst_ni, .ext_rst_i, .opt_we_i,
    .opt_wdata_i (opt_t'(opt_wdata_i)),
    .latch_i, .selfchk_i,
    .prot_eff_o  (prot_eff),
    .sec_eff_o   (sec_eff),
    .erase_all_o
  );

  eeprom_req_screen #(
    .ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE), .OPEN_SZ(OPEN_SZ)
  ) u_screen (
    .clk_i, .rst_ni, .ext_rst_i, .req_valid_i, .req_addr_i, .req_op_i,
    .latch_i,
    .prot_eff_i (prot_eff),
    .stop_i,
    .busy_i     (busy),
    .acc_wr_o   (acc_wr),
    .resp_valid_o, .resp_ok_o, .rej_flag_o
  );

  eeprom_pump_ctrl u_pump (
    .clk_i, .rst_ni, .ext_rst_i,
    .acc_wr_i (acc_wr),
    .op_done_i, .stop_i, .wait_i, .rc_sel_i,
    .busy_o   (busy),
    .pump_en_o, .pump_clk_sel_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        test_ok_q <= 1'b0;
    else if (ext_rst_i) test_ok_q <= 1'b0;
    else                test_ok_q <= test_req_i && sec_eff;
  end
  assign test_ok_o = test_ok_q;

  AST_SEC_BLOCKS_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_eff && !ext_rst_i |=> !test_ok_o); // R7
endmodule

// File: tb/eeprom_guard_tb_top.sv
module eeprom_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {addr[12:4], op[3:2], latch[1], expect_ok[0]}
  localparam logic [12:0] VEC [NV] = '{
    {9'h100, 2'd1, 1'b1, 1'b1},  // R1 open erase
    {9'h11F, 2'd2, 1'b1, 1'b1},  // R1 open program
    {9'h120, 2'd1, 1'b1, 1'b0},  // R2 locked erase
    {9'h1FF, 2'd2, 1'b1, 1'b0},  // R2 locked program
    {9'h1FF, 2'd0, 1'b0, 1'b1},  // R2 read locked
    {9'h150, 2'd0, 1'b0, 1'b1},  // R1 read
    {9'h100, 2'd2, 1'b0, 1'b0},  // R5 no latch
    {9'h0FF, 2'd0, 1'b0, 1'b0},  // R5 below range
    {9'h000, 2'd1, 1'b1, 1'b0},  // R5 wraps out of range
    {9'h110, 2'd3, 1'b1, 1'b0}   // R5 reserved op
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ext_rst_i = 0, opt_we_i = 0, latch_i = 0, req_valid_i = 0;
  logic [1:0] opt_wdata_i = '0, req_op_i = '0;
  logic [8:0] req_addr_i = '0;
  logic op_done_i = 0, stop_i = 0, wait_i = 0, rc_sel_i = 0, test_req_i = 0, selfchk_i = 0;
  logic resp_valid_o, resp_ok_o, rej_flag_o, pump_en_o, pump_clk_sel_o, test_ok_o, erase_all_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_guard dut_i (.clk_i(clk), .*);

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic req(input logic [8:0] a, input logic [1:0] op, input logic l);
    req_addr_i = a; req_op_i = op; latch_i = l; req_valid_i = 1;
    @(negedge clk);
    req_valid_i = 0; latch_i = 0;
  endtask

  task automatic pulse_done();
    op_done_i = 1; @(negedge clk); op_done_i = 0;
  endtask

  task automatic pulse_ext();
    ext_rst_i = 1; @(negedge clk); ext_rst_i = 0;
  endtask

  task automatic opt_wr(input logic [1:0] d, input logic l);
    opt_we_i = 1; opt_wdata_i = d; latch_i = l;
    @(negedge clk);
    opt_we_i = 0; latch_i = 0;
  endtask

  task automatic test_probe(input logic exp, input string tag);
    test_req_i = 1; @(negedge clk); test_req_i = 0;
    chk(test_ok_o, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(resp_valid_o, 0, "R6 reset resp_valid");
    chk(pump_en_o, 0, "R11 reset pump");
    chk(rej_flag_o, 0, "R6 reset rej_flag");
    chk(pump_clk_sel_o, 0, "R12 reset clk sel");
    chk(erase_all_o, 0, "R8 reset erase_all");

    for (int i = 0; i < NV; i++) begin
      req(VEC[i][12:4], VEC[i][3:2], VEC[i][1]);
      chk(resp_valid_o, 1, "R6 table valid");
      chk(resp_ok_o, VEC[i][0], "R1/R2/R5 table verdict");
      chk(rej_flag_o, !VEC[i][0], "R6 table rej_flag");
      if (VEC[i][0] && VEC[i][3:2] != 2'd0) begin
        chk(pump_en_o, 1, "R11 pump after accept");
        pulse_done();
        chk(pump_en_o, 0, "R11 pump off after done");
      end
    end

    // R4: clear without latch ignored
    opt_wr(2'b10, 0);
    pulse_ext();
    req(9'h120, 2'd1, 1);
    chk(resp_ok_o, 0, "R4 clear without latch ignored");
    // R3: clear with latch, not effective until reset
    opt_wr(2'b10, 1);
    req(9'h120, 2'd1, 1);
    chk(resp_ok_o, 0, "R3 still locked before reset");
    pulse_ext();
    req(9'h120, 2'd1, 1);
    chk(resp_ok_o, 1, "R3 unlocked after reset");
    pulse_done();
    opt_wr(2'b11, 0);
    req(9'h1FF, 2'd2, 1);
    chk(resp_ok_o, 1, "R3 relock waits for reset");
    pulse_done();
    pulse_ext();
    req(9'h1FF, 2'd2, 1);
    chk(resp_ok_o, 0, "R3 relocked after reset");

    // R10, R11, R9
    req(9'h100, 2'd1, 1);
    chk(pump_en_o, 1, "R11 pump on");
    wait_i = 1;
    repeat (3) @(negedge clk);
    chk(pump_en_o, 1, "R10 pump held in wait");
    req(9'h101, 2'd2, 1);
    chk(resp_ok_o, 0, "R11 busy rejects");
    chk(pump_en_o, 1, "R10 pump still on");
    stop_i = 1;
    @(negedge clk);
    chk(pump_en_o, 0, "R9 stop drops pump");
    req(9'h100, 2'd1, 1);
    chk(resp_ok_o, 0, "R9 erase during stop rejected");
    chk(pump_en_o, 0, "R9 pump stays off");
    stop_i = 0; wait_i = 0;
    req(9'h100, 2'd0, 0);
    chk(resp_ok_o, 1, "R1 read accepted");
    chk(pump_en_o, 0, "R11 read leaves pump off");

    // R12
    rc_sel_i = 1; @(negedge clk);
    chk(pump_clk_sel_o, 1, "R12 rc select");
    rc_sel_i = 0; @(negedge clk);
    chk(pump_clk_sel_o, 0, "R12 cpu select");

    // R7, R8
    test_probe(1, "R7 test allowed");
    opt_wr(2'b01, 0);
    test_probe(1, "R7 sec change waits for reset");
    pulse_ext();
    test_probe(0, "R7 test blocked");
    opt_wr(2'b11, 1);
    pulse_ext();
    test_probe(0, "R7 sec write of one ignored");
    selfchk_i = 1; @(negedge clk); selfchk_i = 0;
    chk(erase_all_o, 1, "R8 erase_all pulse");
    @(negedge clk);
    chk(erase_all_o, 0, "R8 erase_all one cycle");
    pulse_ext();
    test_probe(1, "R8 sec restored by self-check");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule